// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

The controller gathers eight hardware interrupt sources: two external pins, three timers, an interval timer, a watchdog and a key-scan input. Each source has a request flag and an enable bit. A single global enable gates all of them. When the CPU signals an instruction boundary and at least one enabled request is pending while the global enable is set, the controller accepts the highest-priority request. At that moment it clears that source's flag and the global enable.

After acceptance the controller runs a context-save phase of a fixed number of cycles. During this phase the CPU pushes its return address and status word. The controller then presents the winning source's vector index and holds it until the CPU acknowledges it. Software reads the flags and enables through plain output buses. It writes the enables, and clears flags, through a small write port that addresses the lower or upper half of each bank.

Interrupts nest only when a service routine sets the global enable again. A later enabled request is then accepted at the next boundary once the controller is idle.

Top module: `irq_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, all flags, all enables and the global enable are 0, and `save_active` and `vec_valid` are 0.
- R2: A falling edge on `ext_pin[k]` (k = 0 or 1) sets flag k on the third rising clock edge after the pin falls, because of two synchroniser stages and one edge stage. A rising edge sets nothing.
- R3: A high level on `int_evt[j]` at a rising edge sets flag j+2 at that edge. Source index map: 0,1 external; 2,3,4 timers; 5 interval timer; 6 watchdog; 7 key scan.
- R4: A flag stays 1 until its source is accepted or software clears it. A flag write clears each flag whose write bit is 0 and leaves the others unchanged. A set event in the same cycle as a clear leaves the flag at 1.
- R5: When `wr_en` is high, `wr_sel` selects the target: 2'b00 loads enables 3:0, 2'b01 loads enables 7:4, 2'b10 writes flags 3:0, and 2'b11 writes flags 7:4, each from `wr_data[3:0]`.
- R6: `gie_set` sets the global enable and `gie_clr` clears it. If both are high, the enable is cleared.
- R7: A request is accepted only when the controller is idle, `cpu_boundary` is 1, and the source's flag, its enable bit and the global enable are all 1.
- R8: Among several eligible requests, the lowest source index wins, so external pin 0 has the highest priority and key scan the lowest.
- R9: At the acceptance edge the winner's flag and the global enable go to 0, and the global enable is cleared even if `gie_set` is high in that cycle. No other flag changes because of the acceptance.
- R10: `save_active` is high for exactly SAVE_LEN cycles starting at the acceptance edge. `vec_valid` follows with `vec_idx` equal to the winner, and both hold until `vec_ack`. The controller is idle from the edge that samples `vec_ack`.
- R11: If software sets the global enable again after a vector is acknowledged, a further pending enabled request is accepted at the next boundary.
- R12: `irq_pend` is 1 exactly when the global enable is 1 and at least one flag with its enable bit set is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 2 | Asynchronous external request pins, active on a falling edge |
| int_evt | input | 6 | Internal event pulses for sources 2 to 7 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 4 | Write data for the selected half |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| cpu_boundary | input | 1 | CPU is at an instruction boundary |
| vec_ack | input | 1 | CPU has taken the vector |
| flag_o | output | 8 | Request flags |
| en_o | output | 8 | Enable bits |
| gie_o | output | 1 | Global enable |
| irq_pend | output | 1 | An eligible request exists |
| save_active | output | 1 | Context-save phase in progress |
| vec_valid | output | 1 | Vector index valid |
| vec_idx | output | 3 | Accepted source index |

## Verification
Internal events and register writes take effect at the next edge. External pins take effect three edges after the fall. The save phase starts at the acceptance edge, and the vector appears SAVE_LEN edges later. The bench runs a behavioural reference model that applies these latencies. It compares every output on each falling clock edge, after all registers have settled and before new inputs are driven. Directed sequences sample at exactly these cycle offsets, and a long pseudo-random phase then exercises overlapping writes, events and handshakes.

// File: rtl/irqc_pkg.sv
// Shared types and write-select codes for the interrupt controller.
package irqc_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_SAVE = 2'b01,
        SQ_VEC  = 2'b10
    } seq_state_t;

    localparam logic [1:0] SEL_EN_LO = 2'b00;
    localparam logic [1:0] SEL_EN_HI = 2'b01;
    localparam logic [1:0] SEL_FL_LO = 2'b10;
    localparam logic [1:0] SEL_FL_HI = 2'b11;
endpackage

// File: rtl/irqc_edge_sync.sv
// Two-stage synchroniser plus falling-edge detector for each external pin.
// Assumes the pins idle high; the stages reset to 1 so reset causes no event.
module irqc_edge_sync #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] fall_o
);
    logic [NPIN-1:0] meta_q, sync_q, prev_q;

    // Shift each pin through two synchroniser stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPIN; g++) begin : g_pin
            // A fall is a high history bit followed by a low synchronised bit.
            assign fall_o[g] = prev_q[g] & ~sync_q[g];
        end
    endgenerate
endmodule

// File: rtl/irqc_req_bank.sv
// Request flags, enable bits and global enable. The write port covers one half
// of a bank per access. Set events override clears in the same cycle.
module irqc_req_bank
    import irqc_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int HALF = NSRC / 2,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [HALF-1:0] wr_data_i,
    input  logic            acc_i,
    input  logic [IDXW-1:0] acc_idx_i,
    input  logic            gie_set_i,
    input  logic            gie_clr_i,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] en_o,
    output logic            gie_o
);
    logic [NSRC-1:0] flag_q, flag_n, en_q, en_n;
    logic            gie_q, gie_n;

    // Next flags: software clears, then the acceptance clear, then set events.
    always_comb begin
        flag_n = flag_q;
        if (wr_en_i && wr_sel_i == SEL_FL_LO)
            flag_n[HALF-1:0] = flag_q[HALF-1:0] & wr_data_i;
        if (wr_en_i && wr_sel_i == SEL_FL_HI)
            flag_n[NSRC-1:HALF] = flag_q[NSRC-1:HALF] & wr_data_i;
        if (acc_i)
            flag_n[acc_idx_i] = 1'b0;
        flag_n = flag_n | set_i;
    end

    // Next enables: direct load of the selected half.
    always_comb begin
        en_n = en_q;
        if (wr_en_i && wr_sel_i == SEL_EN_LO) en_n[HALF-1:0]    = wr_data_i;
        if (wr_en_i && wr_sel_i == SEL_EN_HI) en_n[NSRC-1:HALF] = wr_data_i;
    end

    // Next global enable: acceptance and clear win over set.
    always_comb begin
        if (acc_i || gie_clr_i) gie_n = 1'b0;
        else if (gie_set_i)     gie_n = 1'b1;
        else                    gie_n = gie_q;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
            gie_q  <= 1'b0;
        end else begin
            flag_q <= flag_n;
            en_q   <= en_n;
            gie_q  <= gie_n;
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign gie_o  = gie_q;

    // R3: every set event is visible in the flags after the edge.
    a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    // R9: the accepted source's flag drops unless it was set again.
    a_r9_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !set_i[acc_idx_i]) |=> !flag_o[$past(acc_idx_i)]);

    // R6: a clear request always leaves the global enable low.
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_i |=> !gie_o);
endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority picker: the lowest set index among eligible requests wins.
module irqc_prio #(
    parameter int NSRC = 8,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o,
    output logic [NSRC-1:0] grant_o
);
    // Scan from the lowest priority upwards so the lowest index is kept.
    always_comb begin
        idx_o   = '0;
        grant_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o   = IDXW'(i);
                grant_o = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |req_i;

    // R8: at most one source is granted, and only a requesting one.
    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && ((grant_o & ~req_i) == '0));
endmodule

// File: rtl/irqc_seq.sv
// Acceptance sequencer: idle, context-save phase of SAVE_LEN cycles, then
// vector presentation held until the CPU acknowledges it.
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int SAVE_LEN = 3,
    localparam int IDXW = $clog2(NSRC),
    localparam int CW   = $clog2(SAVE_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary_i,
    input  logic            any_i,
    input  logic [IDXW-1:0] win_i,
    input  logic            vec_ack_i,
    output logic            acc_o,
    output logic            save_o,
    output logic            vec_valid_o,
    output logic [IDXW-1:0] vec_idx_o
);
    seq_state_t      st_q;
    logic [CW-1:0]   cnt_q;
    logic [IDXW-1:0] win_q;

    // Accept only from idle at an instruction boundary.
    assign acc_o = (st_q == SQ_IDLE) && boundary_i && any_i;

    // Phase sequencing and capture of the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
            win_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: if (acc_o) begin
                    st_q  <= SQ_SAVE;
                    cnt_q <= '0;
                    win_q <= win_i;
                end
                SQ_SAVE: if (cnt_q == CW'(SAVE_LEN - 1)) st_q <= SQ_VEC;
                         else cnt_q <= cnt_q + 1'b1;
                SQ_VEC:  if (vec_ack_i) st_q <= SQ_IDLE;
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign save_o      = (st_q == SQ_SAVE);
    assign vec_valid_o = (st_q == SQ_VEC);
    assign vec_idx_o   = win_q;

    // R10: the save phase is always followed directly by the vector.
    a_r10_save_then_vec: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(save_o) |-> vec_valid_o);

    // R10: an unacknowledged vector holds with a stable index.
    a_r10_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !vec_ack_i) |=> (vec_valid_o && $stable(vec_idx_o)));

    // R10: acknowledgement returns the sequencer to idle.
    a_r10_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_ack_i) |=> (!vec_valid_o && !save_o));
endmodule

// File: rtl/irq_ctrl.sv
// Top level of the vectored maskable interrupt controller. Source 0 and 1 are
// external pins; sources 2..NSRC-1 come from internal event pulses.
module irq_ctrl #(
    parameter int NSRC     = 8,
    parameter int NEXT     = 2,
    parameter int SAVE_LEN = 3,
    localparam int HALF = NSRC / 2,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NEXT-1:0]      ext_pin,
    input  logic [NSRC-NEXT-1:0] int_evt,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [HALF-1:0]      wr_data,
    input  logic                 gie_set,
    input  logic                 gie_clr,
    input  logic                 cpu_boundary,
    input  logic                 vec_ack,
    output logic [NSRC-1:0]      flag_o,
    output logic [NSRC-1:0]      en_o,
    output logic                 gie_o,
    output logic                 irq_pend,
    output logic                 save_active,
    output logic                 vec_valid,
    output logic [IDXW-1:0]      vec_idx
);
    logic [NEXT-1:0] ext_fall;
    logic [NSRC-1:0] set_vec, elig, grant;
    logic            any_elig, acc;
    logic [IDXW-1:0] win;

    irqc_edge_sync #(.NPIN(NEXT)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .fall_o(ext_fall)
    );

    assign set_vec = {int_evt, ext_fall};

    irqc_req_bank #(.NSRC(NSRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .acc_i(acc), .acc_idx_i(win),
        .gie_set_i(gie_set), .gie_clr_i(gie_clr),
        .flag_o(flag_o), .en_o(en_o), .gie_o(gie_o)
    );

    // Eligible requests: flag, enable and global enable all set.
    assign elig     = flag_o & en_o & {NSRC{gie_o}};
    assign irq_pend = |elig;

    irqc_prio #(.NSRC(NSRC)) u_prio (
        .clk(clk), .rst_n(rst_n), .req_i(elig),
        .any_o(any_elig), .idx_o(win), .grant_o(grant)
    );

    irqc_seq #(.NSRC(NSRC), .SAVE_LEN(SAVE_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(cpu_boundary),
        .any_i(any_elig), .win_i(win), .vec_ack_i(vec_ack),
        .acc_o(acc), .save_o(save_active),
        .vec_valid_o(vec_valid), .vec_idx_o(vec_idx)
    );

    // R7: acceptance needs the global enable, a boundary and an enabled flag.
    a_r7_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (gie_o && cpu_boundary && ((grant & flag_o & en_o) != '0)));

    // R9: acceptance drops the global enable at the same edge.
    a_r9_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !gie_o);

    // R10: the save phase begins at the acceptance edge.
    a_r10_save_start: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> save_active);
endmodule

// File: tb/tb_irq_ctrl.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed sequences with hand-computed expectations.
module tb_irq_ctrl;
    localparam int NSRC = 8;
    localparam int SAVE_LEN = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin = 2'b11;
    logic [5:0] int_evt = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [3:0] wr_data = '0;
    logic       gie_set = 1'b0, gie_clr = 1'b0, cpu_boundary = 1'b0, vec_ack = 1'b0;
    logic [7:0] flag_o, en_o;
    logic       gie_o, irq_pend, save_active, vec_valid;
    logic [2:0] vec_idx;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_ctrl #(.NSRC(NSRC), .NEXT(2), .SAVE_LEN(SAVE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_evt(int_evt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .gie_set(gie_set), .gie_clr(gie_clr), .cpu_boundary(cpu_boundary),
        .vec_ack(vec_ack), .flag_o(flag_o), .en_o(en_o), .gie_o(gie_o),
        .irq_pend(irq_pend), .save_active(save_active), .vec_valid(vec_valid),
        .vec_idx(vec_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [7:0] m_flag = '0, m_en = '0;
    bit         m_gie = 0;
    int         m_state = 0;   // 0 idle, 1 save, 2 vector
    int         m_cnt = 0, m_win = 0;
    logic [1:0] m_s1 = 2'b11, m_s2 = 2'b11, m_s3 = 2'b11;

    // Model update on each rising edge, from pre-edge values.
    always @(posedge clk) begin : model
        logic [7:0] setv, elig, nf, ne;
        bit acc, ng;
        int w;
        if (!rst_n) begin
            m_flag = '0; m_en = '0; m_gie = 0; m_state = 0; m_cnt = 0; m_win = 0;
            m_s1 = 2'b11; m_s2 = 2'b11; m_s3 = 2'b11;
        end else begin
            setv = {int_evt, m_s3 & ~m_s2};
            elig = m_flag & m_en & {8{m_gie}};
            acc  = (m_state == 0) && cpu_boundary && (elig != 0);
            w = 0;
            for (int i = 7; i >= 0; i--) if (elig[i]) w = i;
            nf = m_flag; ne = m_en;
            if (wr_en && wr_sel == 2'b10) nf[3:0] = m_flag[3:0] & wr_data;
            if (wr_en && wr_sel == 2'b11) nf[7:4] = m_flag[7:4] & wr_data;
            if (wr_en && wr_sel == 2'b00) ne[3:0] = wr_data;
            if (wr_en && wr_sel == 2'b01) ne[7:4] = wr_data;
            if (acc) nf[w] = 1'b0;
            nf = nf | setv;
            ng = acc || gie_clr ? 0 : (gie_set ? 1 : m_gie);
            case (m_state)
                0: if (acc) begin m_state = 1; m_cnt = 0; m_win = w; end
                1: if (m_cnt == SAVE_LEN - 1) m_state = 2; else m_cnt++;
                default: if (vec_ack) m_state = 0;
            endcase
            m_flag = nf; m_en = ne; m_gie = ng;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 flags vs model", flag_o, m_flag);
            check("R5 enables vs model", en_o, m_en);
            check("R6 gie vs model", gie_o, m_gie);
            check("R12 pend vs model", irq_pend, m_gie && ((m_flag & m_en) != 0));
            check("R10 save vs model", save_active, m_state == 1);
            check("R10 valid vs model", vec_valid, m_state == 2);
            if (m_state == 2) check("R8 vec_idx vs model", vec_idx, m_win);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        cyc(1);
        wr_en = 0;
    endtask

    initial begin : stim
        cyc(3);
        rst_n = 1;
        // R1: reset state.
        check("R1 flags", flag_o, 0);
        check("R1 enables", en_o, 0);
        check("R1 gie", gie_o, 0);
        check("R1 save", save_active, 0);
        check("R1 vec_valid", vec_valid, 0);

        // R5: enable writes to each half.
        wr(2'b00, 4'hF);
        wr(2'b01, 4'hF);
        check("R5 enables loaded", en_o, 8'hFF);

        // R2: external pin 0 falls; flag appears after the third edge.
        ext_pin[0] = 0;
        cyc(2);
        check("R2 not yet", flag_o[0], 0);
        cyc(1);
        check("R2 ext0 set", flag_o[0], 1);
        wr(2'b10, 4'b1110);
        check("R4 clear ext0", flag_o[0], 0);
        ext_pin[0] = 1;
        cyc(5);
        check("R2 rising ignored", flag_o[0], 0);

        // R3: internal events map to index j+2.
        int_evt = 6'b001010;
        cyc(1);
        int_evt = 0;
        check("R3 timer1 and interval", flag_o, 8'b0010_1000);

        // R4: write-one keeps; clear beaten by same-cycle set.
        wr(2'b10, 4'b1111);
        check("R4 write one keeps", flag_o, 8'b0010_1000);
        wr_en = 1; wr_sel = 2'b11; wr_data = 4'b0000; int_evt = 6'b001000;
        cyc(1);
        wr_en = 0; int_evt = 0;
        check("R4 set beats clear", flag_o, 8'b0010_1000);

        // R7: boundary without global enable accepts nothing.
        cpu_boundary = 1;
        cyc(2);
        check("R7 no gie no accept", save_active, 0);
        cpu_boundary = 0;

        // R6: set and clear together leaves gie low.
        gie_set = 1; gie_clr = 1;
        cyc(1);
        gie_clr = 0;
        check("R6 clear wins", gie_o, 0);
        cyc(1);
        gie_set = 0;
        check("R6 set", gie_o, 1);
        check("R12 pend", irq_pend, 1);

        // R8/R9/R10: accept the higher-priority source 3.
        gie_set = 1; cpu_boundary = 1;
        cyc(1);
        gie_set = 0; cpu_boundary = 0;
        check("R9 winner cleared", flag_o, 8'b0010_0000);
        check("R9 gie cleared over set", gie_o, 0);
        check("R10 save start", save_active, 1);
        cyc(SAVE_LEN - 1);
        check("R10 save end", save_active, 1);
        cyc(1);
        check("R10 vector valid", vec_valid, 1);
        check("R8 priority idx", vec_idx, 3);
        cyc(2);
        check("R10 vector held", vec_valid, 1);
        vec_ack = 1;
        cyc(1);
        vec_ack = 0;
        check("R10 released", vec_valid, 0);

        // R11: software re-enable lets the remaining request through.
        gie_set = 1;
        cyc(1);
        gie_set = 0; cpu_boundary = 1;
        cyc(1);
        cpu_boundary = 0;
        check("R11 nested accept", save_active, 1);
        cyc(SAVE_LEN);
        check("R11 nested idx", vec_idx, 5);
        vec_ack = 1;
        cyc(1);
        vec_ack = 0;

        // Pseudo-random phase checked by the model.
        for (int k = 0; k < 4000; k++) begin
            ext_pin      = 2'($urandom);
            int_evt      = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
            wr_en        = ($urandom % 6 == 0);
            wr_sel       = 2'($urandom);
            wr_data      = 4'($urandom);
            gie_set      = ($urandom % 5 == 0);
            gie_clr      = ($urandom % 17 == 0);
            cpu_boundary = ($urandom % 2 == 0);
            vec_ack      = ($urandom % 3 == 0);
            cyc(1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule